// File: doc/BRIEF.md
# CRC Accumulate Instruction Unit

This unit carries out eight register-operand CRC accumulate instructions for a 64-bit core. A start pulse presents a 32-bit instruction word and two 64-bit source operands. The unit decodes the instruction. It takes the running 32-bit checksum from one operand and the message from the other. It then folds between one and eight message bytes into the checksum, one byte per clock, lowest byte first. When it finishes it presents a sign-extended 64-bit writeback value together with the destination register index.

Two reflected polynomials are supported: CRC-32 and the Castagnoli variant CRC-32C. The checksum is neither inverted on entry nor on exit. An instruction word outside the family is rejected with a one-cycle illegal flag and produces no writeback.

The controller has four named states:
- IDLE waits for a start.
- RUN folds one byte per cycle.
- FINISH presents the result for one cycle.
- REJECT flags an illegal instruction for one cycle.

Its transitions are:
- IDLE→RUN on a start with a legal word.
- IDLE→REJECT on a start with an illegal word.
- RUN→RUN while more than one byte is left.
- RUN→FINISH on the last byte.
- FINISH→IDLE and REJECT→IDLE unconditionally.

Top module: `crc_exec_unit`

## Requirements
- R1: A start in IDLE is legal only when instruction bits [31:18] equal 14'b00000000001001. Any other value raises `illegal_o` for exactly the one cycle after the start edge, with `busy_o`, `done_o` and `wb_valid_o` low, and no result follows.
- R2: Instruction bit 17 selects the polynomial. A value of 0 selects reflected CRC-32 (0xEDB88320), and a value of 1 selects reflected CRC-32C (0x82F63B78).
- R3: Instruction bits [16:15] give the message length: 00 is 1 byte, 01 is 2 bytes, 10 is 4 bytes and 11 is 8 bytes.
- R4: The starting checksum is `rk_i[31:0]`, and `rk_i[63:32]` has no effect. The message is `rj_i` masked to the selected length, so bytes above the length have no effect.
- R5: Each byte is folded as crc = (crc >> 8) ^ T[(crc ^ byte) & 0xFF], where T is the reflected table of the selected polynomial. Bytes are folded least significant first, with no inversion of the checksum on entry or exit.
- R6: `wb_data_o` is the 32-bit result sign-extended to 64 bits.
- R7: `wb_idx_o` equals instruction bits [4:0] of the accepted instruction.
- R8: `done_o` and `wb_valid_o` are high together for exactly one cycle, N clock edges after the start edge, where N is the byte count. `busy_o` is high from the edge after the start through the done cycle.
- R9: A start while `busy_o` is high is ignored. The running instruction completes with its own result, and no extra result follows.
- R10: After reset, `busy_o`, `done_o`, `wb_valid_o` and `illegal_o` are low, and `wb_data_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse; latches instruction and operands when idle |
| insn_i | input | 32 | Instruction word |
| rj_i | input | 64 | Message operand |
| rk_i | input | 64 | Checksum operand (low 32 bits used) |
| busy_o | output | 1 | An accepted instruction is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| wb_valid_o | output | 1 | Writeback value and index are valid |
| wb_idx_o | output | 5 | Destination register index |
| wb_data_o | output | 64 | Sign-extended CRC result |
| illegal_o | output | 1 | One-cycle pulse for an instruction outside the family |

## Verification
The bench builds the unit with its default parameters: a 64-bit operand width, a 32-bit checksum and 8-bit bytes. With these values every length code from one to eight bytes is reachable, including the case that keeps the whole operand. Both polynomials can be exercised with results whose bit 31 is set and results whose bit 31 is clear, so both sign-extension outcomes are covered. A full eight-byte run lasts long enough that a second start can be injected mid-run.

// File: rtl/crc_exec_pkg.sv
package crc_exec_pkg;

    localparam int XLEN  = 64;
    localparam int CRCW  = 32;
    localparam int BYTEW = 8;

    localparam logic [CRCW-1:0] POLY_CRC32  = 32'hEDB88320;
    localparam logic [CRCW-1:0] POLY_CRC32C = 32'h82F63B78;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FINISH,
        ST_REJECT
    } crc_state_e;

    typedef struct packed {
        logic       legal;
        logic       castagnoli;
        logic [1:0] size_code;
        logic [4:0] rd;
    } crc_op_t;

endpackage

// File: rtl/crc_insn_decode.sv
module crc_insn_decode
    import crc_exec_pkg::*;
(
    input  logic [16:0] opc_i,
    input  logic [4:0]  rd_i,
    output crc_op_t     op_o
);
    localparam logic [13:0] FAMILY = 14'b00000000001001;

    always_comb begin
        op_o.legal      = (opc_i[16:3] == FAMILY);
        op_o.castagnoli = opc_i[2];
        op_o.size_code  = opc_i[1:0];
        op_o.rd         = rd_i;
    end
endmodule

// File: rtl/crc_byte_step.sv
module crc_byte_step #(
    parameter int              CW     = 32,
    parameter int              BW     = 8,
    parameter logic [CW-1:0]   POLY_A = 32'hEDB88320,
    parameter logic [CW-1:0]   POLY_B = 32'h82F63B78
) (
    input  logic [CW-1:0] crc_i,
    input  logic [BW-1:0] byte_i,
    input  logic          sel_b_i,
    output logic [CW-1:0] crc_o
);
    logic [CW-1:0] poly;
    logic [CW-1:0] stage [BW+1];

    assign poly     = sel_b_i ? POLY_B : POLY_A;
    assign stage[0] = crc_i ^ {{(CW-BW){1'b0}}, byte_i};

    for (genvar i = 0; i < BW; i++) begin : g_bit
        assign stage[i+1] = (stage[i] >> 1) ^ (stage[i][0] ? poly : '0);
    end

    assign crc_o = stage[BW];
endmodule

// File: rtl/crc_exec_unit.sv
module crc_exec_unit
    import crc_exec_pkg::*;
#(
    parameter int XW = XLEN,
    parameter int CW = CRCW,
    parameter int BW = BYTEW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [31:0]   insn_i,
    input  logic [XW-1:0] rj_i,
    input  logic [XW-1:0] rk_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          wb_valid_o,
    output logic [4:0]    wb_idx_o,
    output logic [XW-1:0] wb_data_o,
    output logic          illegal_o
);
    localparam int MAXB = XW / BW;
    localparam int CNTW = $clog2(MAXB + 1);

    crc_state_e    state_q, state_nx;
    crc_op_t       op;
    logic [CW-1:0] crc_q, crc_step;
    logic [XW-1:0] msg_q, msg_masked;
    logic [CNTW-1:0] left_q, nbytes;
    logic          castag_q;
    logic [4:0]    rd_q;
    logic          accept;
    logic          unused_bits;

    assign unused_bits = ^{insn_i[14:5], rk_i[XW-1:CW]};

    crc_insn_decode u_decode (
        .opc_i (insn_i[31:15]),
        .rd_i  (insn_i[4:0]),
        .op_o  (op)
    );

    crc_byte_step #(
        .CW     (CW),
        .BW     (BW),
        .POLY_A (POLY_CRC32),
        .POLY_B (POLY_CRC32C)
    ) u_step (
        .crc_i   (crc_q),
        .byte_i  (msg_q[BW-1:0]),
        .sel_b_i (castag_q),
        .crc_o   (crc_step)
    );

    assign nbytes = CNTW'(1) << op.size_code;
    assign accept = (state_q == ST_IDLE) && start_i && op.legal;

    always_comb begin
        for (int b = 0; b < MAXB; b++) begin
            msg_masked[b*BW +: BW] = (CNTW'(b) < nbytes) ? rj_i[b*BW +: BW] : '0;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_nx = op.legal ? ST_RUN : ST_REJECT;
            ST_RUN:    if (left_q == CNTW'(1)) state_nx = ST_FINISH;
            ST_FINISH: state_nx = ST_IDLE;
            ST_REJECT: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q    <= '0;
            msg_q    <= '0;
            left_q   <= '0;
            castag_q <= 1'b0;
            rd_q     <= '0;
        end else if (accept) begin
            crc_q    <= rk_i[CW-1:0];
            msg_q    <= msg_masked;
            left_q   <= nbytes;
            castag_q <= op.castagnoli;
            rd_q     <= op.rd;
        end else if (state_q == ST_RUN) begin
            crc_q  <= crc_step;
            msg_q  <= msg_q >> BW;
            left_q <= left_q - CNTW'(1);
        end
    end

    // outputs
    always_comb begin
        busy_o     = 1'b0;
        done_o     = 1'b0;
        wb_valid_o = 1'b0;
        illegal_o  = 1'b0;
        wb_idx_o   = rd_q;
        wb_data_o  = '0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_RUN:    busy_o = 1'b1;
            ST_FINISH: begin
                busy_o     = 1'b1;
                done_o     = 1'b1;
                wb_valid_o = 1'b1;
                wb_data_o  = {{(XW-CW){crc_q[CW-1]}}, crc_q};
            end
            ST_REJECT: illegal_o = 1'b1;
            default:   ;
        endcase
    end
endmodule

// File: rtl/crc_exec_chk.sv
module crc_exec_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic [31:0] insn_i,
    input logic        busy_o,
    input logic        done_o,
    input logic        wb_valid_o,
    input logic [63:0] wb_data_o,
    input logic        illegal_o
);
    logic legal_w;
    assign legal_w = (insn_i[31:18] == 14'b00000000001001);

    AST_LEGAL_START: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && !illegal_o && legal_w) |=> (busy_o && !illegal_o)); // R1
    AST_ILLEGAL_START: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && !illegal_o && !legal_w) |=> (illegal_o && !busy_o)); // R1
    AST_ILLEGAL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |=> !illegal_o); // R1
    AST_ILLEGAL_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (!wb_valid_o && !done_o)); // R1
    AST_SIGN_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid_o |-> (wb_data_o[63:32] == {32{wb_data_o[31]}})); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o); // R8
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o); // R9
endmodule

bind crc_exec_unit crc_exec_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .insn_i     (insn_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .wb_valid_o (wb_valid_o),
    .wb_data_o  (wb_data_o),
    .illegal_o  (illegal_o)
);

// File: tb/test_crc_exec_unit.sv
module test_crc_exec_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] insn_i = '0;
    logic [63:0] rj_i = '0;
    logic [63:0] rk_i = '0;
    logic        busy_o, done_o, wb_valid_o, illegal_o;
    logic [4:0]  wb_idx_o;
    logic [63:0] wb_data_o;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    crc_exec_unit i_crc_exec_unit (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .insn_i(insn_i),
        .rj_i(rj_i), .rk_i(rk_i), .busy_o(busy_o), .done_o(done_o),
        .wb_valid_o(wb_valid_o), .wb_idx_o(wb_idx_o), .wb_data_o(wb_data_o),
        .illegal_o(illegal_o)
    );

    typedef struct packed {
        logic        c;
        logic [1:0]  sz;
        logic [4:0]  rd;
        logic [63:0] rj;
        logic [63:0] rk;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd0, 5'd1,  64'h0000_0000_0000_0001, 64'h0000_0000_0000_0000},
        '{1'b1, 2'd0, 5'd2,  64'h0000_0000_0000_0001, 64'h0000_0000_0000_0000},
        '{1'b0, 2'd1, 5'd3,  64'h0000_0000_0000_BEEF, 64'h0000_0000_FFFF_FFFF},
        '{1'b1, 2'd1, 5'd4,  64'h0000_0000_0000_1234, 64'h0000_0000_1357_9BDF},
        '{1'b0, 2'd2, 5'd5,  64'h0000_0000_DEAD_BEEF, 64'h0000_0000_0BAD_F00D},
        '{1'b1, 2'd2, 5'd6,  64'h0000_0000_3433_3231, 64'h0000_0000_FFFF_FFFF},
        '{1'b0, 2'd3, 5'd7,  64'h0123_4567_89AB_CDEF, 64'h0000_0000_8000_0000},
        '{1'b1, 2'd3, 5'd31, 64'hFEDC_BA98_7654_3210, 64'h0000_0000_0000_0001},
        '{1'b0, 2'd3, 5'd0,  64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000},
        '{1'b1, 2'd2, 5'd9,  64'h8000_0000_8000_0000, 64'h0000_0000_7FFF_FFFF}
    };

    function automatic logic [31:0] model(input logic [31:0] acc, input logic [63:0] msg,
                                          input logic c, input logic [1:0] sz);
        logic [31:0] p = c ? 32'h82F63B78 : 32'hEDB88320;
        int n = 1 << sz;
        for (int i = 0; i < n; i++) begin
            acc = acc ^ {24'h0, msg[8*i +: 8]};
            for (int k = 0; k < 8; k++) acc = acc[0] ? ((acc >> 1) ^ p) : (acc >> 1);
        end
        return acc;
    endfunction

    function automatic logic [63:0] sx(input logic [31:0] v);
        return {{32{v[31]}}, v};
    endfunction

    function automatic logic [31:0] mk_insn(input logic c, input logic [1:0] sz, input logic [4:0] rd);
        return {14'b00000000001001, c, sz, 5'd7, 5'd9, rd};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // run one instruction; sample at negedges
    task automatic run_op(input logic [31:0] insn, input logic [63:0] rj, input logic [63:0] rk,
                          output int lat, output logic [63:0] data, output logic [4:0] idx);
        @(negedge clk);
        insn_i = insn; rj_i = rj; rk_i = rk; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 0;
        while (!done_o && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        data = wb_data_o;
        idx  = wb_idx_o;
    endtask

    initial begin
        #(8 * 150000);
        bad++; total++;
        $display("FAIL watchdog R8 actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int lat;
        int dones;
        logic [63:0] d;
        logic [4:0] ix;
        logic [31:0] e;

        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 busy", busy_o, 0);
        chk("R10 done", done_o, 0);
        chk("R10 wb_valid", wb_valid_o, 0);
        chk("R10 illegal", illegal_o, 0);
        chk("R10 wb_data", wb_data_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: R2 R3 R5 R6 R7 R8
        for (int v = 0; v < NV; v++) begin
            run_op(mk_insn(VECS[v].c, VECS[v].sz, VECS[v].rd), VECS[v].rj, VECS[v].rk, lat, d, ix);
            e = model(VECS[v].rk[31:0], VECS[v].rj, VECS[v].c, VECS[v].sz);
            chk("R5 result", d, sx(e));
            chk("R7 index", {59'h0, ix}, {59'h0, VECS[v].rd});
            chk("R8 latency", lat, 1 << VECS[v].sz);
            chk("R8 wb_valid", wb_valid_o, 1);
            @(negedge clk);
            chk("R8 done one cycle", {busy_o, done_o, wb_valid_o}, 0);
        end

        // R2 known table entries, R6 sign extension
        run_op(mk_insn(1'b0, 2'd0, 5'd1), 64'h1, 64'h0, lat, d, ix);
        chk("R2 crc32 T[1]", d, 64'h0000_0000_7707_3096);
        run_op(mk_insn(1'b1, 2'd0, 5'd1), 64'h1, 64'h0, lat, d, ix);
        chk("R6 crc32c T[1] sign", d, 64'hFFFF_FFFF_F26B_8303);

        // R4 upper operand bits ignored
        run_op(mk_insn(1'b0, 2'd0, 5'd4), 64'hFFFF_FFFF_FFFF_FF5A, 64'hABCD_0000_1111_2222, lat, d, ix);
        chk("R4 masked", d, sx(model(32'h1111_2222, 64'h5A, 1'b0, 2'd0)));
        run_op(mk_insn(1'b1, 2'd1, 5'd4), 64'h9999_8888_7777_A55A, 64'hFFFF_FFFF_0000_0000, lat, d, ix);
        chk("R4 masked half", d, sx(model(32'h0, 64'hA55A, 1'b1, 2'd1)));
        // R3 size 4 ignores byte 4
        run_op(mk_insn(1'b0, 2'd2, 5'd4), 64'h0000_00FF_0102_0304, 64'h0, lat, d, ix);
        chk("R3 four bytes", d, sx(model(32'h0, 64'h0102_0304, 1'b0, 2'd2)));

        // R1 illegal opcode
        @(negedge clk);
        insn_i = 32'h0028_0003; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R1 illegal raised", {illegal_o, busy_o, wb_valid_o, done_o}, 4'b1000);
        @(negedge clk);
        chk("R1 illegal one cycle", illegal_o, 0);
        dones = 0;
        for (int t = 0; t < 10; t++) begin
            @(negedge clk);
            if (done_o || wb_valid_o || busy_o) dones++;
        end
        chk("R1 no writeback", dones, 0);

        // R9 start while busy ignored
        @(negedge clk);
        insn_i = mk_insn(1'b0, 2'd3, 5'd12); rj_i = 64'h1122_3344_5566_7788;
        rk_i = 64'h0000_0000_CAFE_F00D; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        insn_i = mk_insn(1'b1, 2'd0, 5'd20); rj_i = 64'h55; rk_i = 64'h0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        dones = 0;
        for (int t = 0; t < 20; t++) begin
            if (done_o) begin
                dones++;
                chk("R9 first result kept", wb_data_o,
                    sx(model(32'hCAFE_F00D, 64'h1122_3344_5566_7788, 1'b0, 2'd3)));
                chk("R9 first index kept", {59'h0, wb_idx_o}, 64'd12);
            end
            @(negedge clk);
        end
        chk("R9 single done", dones, 1);
        chk("R9 idle after", busy_o, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule